// File: doc/BRIEF.md
# End-Around-Carry Fibonacci Sequence Generator

The block is a free-running pseudo-random number source with no data input. It holds a pair of WIDTH-bit words X and Y and one carry bit C. On every enabled clock it forms the sum of X, Y and C, moves X into Y, keeps the low WIDTH bits of the sum as the new X and keeps the bit that overflowed as the new C. That overflow is added back in on the following step. Plain Fibonacci modulo 2^WIDTH returns to its start after about one and a half times 2^WIDTH steps. Feeding the overflow back in stretches each orbit to roughly half of the squared state space. For the widths that behave well, the reachable states form exactly two orbits. The current X appears on the output every cycle.

A seed for X, Y and C can be written through a load strobe. The two self-looping states cannot be left once entered, so a seed that names either of them is refused and flagged. A period counter measures how many steps it takes to come back to the seed state, which lets a test confirm orbit lengths. A build parameter can turn the carry feedback off, which gives the plain modulo sequence for comparison.

Top module: `eacfib_gen`

## Requirements
- R1: After reset, rand_o equals RESET_X (default 1), Y holds RESET_Y (default 0), the carry is 0, period_o is 0, and both period_hit_o and seed_err_o are 0. This reset state is also the seed that the period counter compares against.
- R2: When en_i is 1 and load_i is 0, one clock edge moves the state to X' = (X + Y + C) mod 2^WIDTH, Y' = X and C' = bit WIDTH of that sum, and rand_o then shows X'.
- R3: When en_i and load_i are both 0, the state and rand_o do not change.
- R4: An accepted load (load_i = 1) writes seed_x_i, seed_y_i and seed_c_i into X, Y and C, so rand_o equals seed_x_i after the edge. A load takes priority over en_i, so no step happens in that cycle.
- R5: Two seeds are refused: X = Y = 0 with C = 0, and, with the carry on, X and Y all ones with C = 1. A refused load leaves the state unchanged, ignores en_i in that cycle, and drives seed_err_o high for exactly the one cycle after the edge.
- R6: With USE_CARRY = 0 the carry is held at 0 and seed_c_i is ignored, so the sequence is plain Fibonacci modulo 2^WIDTH. At WIDTH = 4 the seed (1,0) comes back after 24 steps. The all-ones seed is accepted and steps to X = 14.
- R7: period_o is 2*WIDTH+2 bits wide and counts enabled steps since reset or since the last accepted load. period_hit_o rises on the first step whose new state equals the seed, and period_o then holds that step count. An accepted load clears both.
- R8: With the carry on at WIDTH = 4, the seed (1,0,0) and the seed (3,2,0) each return after exactly 135 steps.
- R9: After period_hit_o is set, enabled steps still advance the sequence as in R2, while period_o stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Advance one step |
| load_i | input | 1 | Write the seed (takes priority over en_i) |
| seed_x_i | input | WIDTH | Seed value for X |
| seed_y_i | input | WIDTH | Seed value for Y |
| seed_c_i | input | 1 | Seed value for the carry |
| rand_o | output | WIDTH | Current X |
| seed_err_o | output | 1 | One-cycle pulse after a refused seed |
| period_o | output | 2*WIDTH+2 | Steps since the seed was set |
| period_hit_o | output | 1 | The seed state has recurred |

## Verification
The bench goes after the overflow path, the period counter and the load corner cases. A generator that dropped or delayed the carry would diverge from the reference at 16 bits within a few steps. It would also return to its seed after 24 steps instead of 135 at 4 bits, and a carry that leaked into the disabled mode would step the all-ones seed to 15 instead of 14. A counter that kept running, or that set its flag one step early or late, shows up as a wrong count at the 135th step and just around it. A generator that accepted a self-looping seed, or that let en_i step during a refused load, changes rand_o when it must hold. The checks also cover the error pulse lasting longer than one cycle and the counter failing to restart after a new accepted seed.

// File: rtl/eacfib_pkg.sv
package eacfib_pkg;

  typedef enum logic [1:0] {
    SEED_OK   = 2'd0,
    SEED_ZERO = 2'd1,
    SEED_SAT  = 2'd2
  } seed_class_e;

endpackage

// File: rtl/eacfib_step.sv
module eacfib_step #(
  parameter int unsigned WIDTH     = 16,
  parameter bit          USE_CARRY = 1'b1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o,
  output logic             c_o
);

  localparam int unsigned SUM_W = WIDTH + 1;

  logic [SUM_W-1:0] sum;

  generate
    if (USE_CARRY) begin : g_eac
      assign sum = {1'b0, x_i} + {1'b0, y_i} + SUM_W'(c_i);
      assign c_o = sum[WIDTH];
    end else begin : g_plain
      logic unused_c;
      assign unused_c = c_i;
      assign sum = {1'b0, x_i} + {1'b0, y_i};
      assign c_o = 1'b0;
    end
  endgenerate

  assign x_o = sum[WIDTH-1:0];
  assign y_o = x_i;

endmodule

// File: rtl/eacfib_seed_check.sv
module eacfib_seed_check
  import eacfib_pkg::*;
#(
  parameter int unsigned WIDTH     = 16,
  parameter bit          USE_CARRY = 1'b1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output seed_class_e      cls_o
);

  logic is_zero;
  logic is_sat;

  // carry input counts only when the feedback exists
  assign is_zero = (x_i == '0) && (y_i == '0) && !(USE_CARRY && c_i);
  assign is_sat  = USE_CARRY && c_i && (&x_i) && (&y_i);

  always_comb begin
    if (is_zero)     cls_o = SEED_ZERO;
    else if (is_sat) cls_o = SEED_SAT;
    else             cls_o = SEED_OK;
  end

endmodule

// File: rtl/eacfib_period.sv
module eacfib_period #(
  parameter int unsigned           WIDTH   = 16,
  parameter logic [WIDTH-1:0]      RESET_X = WIDTH'(1),
  parameter logic [WIDTH-1:0]      RESET_Y = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   nx_i,
  input  logic [WIDTH-1:0]   ny_i,
  input  logic               nc_i,
  input  logic [WIDTH-1:0]   ld_x_i,
  input  logic [WIDTH-1:0]   ld_y_i,
  input  logic               ld_c_i,
  output logic [2*WIDTH+1:0] cnt_o,
  output logic               hit_o
);

  localparam int unsigned CNT_W = 2 * WIDTH + 2;

  logic [WIDTH-1:0] seed_x_q, seed_y_q;
  logic             seed_c_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_q;
  logic             back_home;

  assign back_home = (nx_i == seed_x_q) && (ny_i == seed_y_q) && (nc_i == seed_c_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_x_q <= RESET_X;
      seed_y_q <= RESET_Y;
      seed_c_q <= 1'b0;
      cnt_q    <= '0;
      hit_q    <= 1'b0;
    end else if (restart_i) begin
      seed_x_q <= ld_x_i;
      seed_y_q <= ld_y_i;
      seed_c_q <= ld_c_i;
      cnt_q    <= '0;
      hit_q    <= 1'b0;
    end else if (step_i && !hit_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (back_home) hit_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = hit_q;

  AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && !restart_i) |=> $stable(cnt_q)); // R9

  AST_COUNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !hit_q && !restart_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!hit_q && cnt_q == '0)); // R7

endmodule

// File: rtl/eacfib_gen.sv
module eacfib_gen
  import eacfib_pkg::*;
#(
  parameter int unsigned      WIDTH     = 16,
  parameter bit               USE_CARRY = 1'b1,
  parameter logic [WIDTH-1:0] RESET_X   = WIDTH'(1),
  parameter logic [WIDTH-1:0] RESET_Y   = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [WIDTH-1:0]   seed_x_i,
  input  logic [WIDTH-1:0]   seed_y_i,
  input  logic               seed_c_i,
  output logic [WIDTH-1:0]   rand_o,
  output logic               seed_err_o,
  output logic [2*WIDTH+1:0] period_o,
  output logic               period_hit_o
);

  logic [WIDTH-1:0] x_q, y_q;
  logic             c_q;
  logic             err_q;
  logic [WIDTH-1:0] nx, ny;
  logic             nc;
  logic             seed_c_eff;
  seed_class_e      seed_cls;
  logic             load_ok, load_bad, step;

  assign seed_c_eff = USE_CARRY ? seed_c_i : 1'b0;
  assign load_ok    = load_i && (seed_cls == SEED_OK);
  assign load_bad   = load_i && (seed_cls != SEED_OK);
  assign step       = en_i && !load_i;

  eacfib_seed_check #(
    .WIDTH    (WIDTH),
    .USE_CARRY(USE_CARRY)
  ) u_seed_check (
    .x_i  (seed_x_i),
    .y_i  (seed_y_i),
    .c_i  (seed_c_i),
    .cls_o(seed_cls)
  );

  eacfib_step #(
    .WIDTH    (WIDTH),
    .USE_CARRY(USE_CARRY)
  ) u_step (
    .x_i(x_q),
    .y_i(y_q),
    .c_i(c_q),
    .x_o(nx),
    .y_o(ny),
    .c_o(nc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= RESET_X;
      y_q   <= RESET_Y;
      c_q   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= load_bad;
      if (load_ok) begin
        x_q <= seed_x_i;
        y_q <= seed_y_i;
        c_q <= seed_c_eff;
      end else if (step) begin
        x_q <= nx;
        y_q <= ny;
        c_q <= nc;
      end
    end
  end

  eacfib_period #(
    .WIDTH  (WIDTH),
    .RESET_X(RESET_X),
    .RESET_Y(RESET_Y)
  ) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(load_ok),
    .step_i   (step),
    .nx_i     (nx),
    .ny_i     (ny),
    .nc_i     (nc),
    .ld_x_i   (seed_x_i),
    .ld_y_i   (seed_y_i),
    .ld_c_i   (seed_c_eff),
    .cnt_o    (period_o),
    .hit_o    (period_hit_o)
  );

  assign rand_o     = x_q;
  assign seed_err_o = err_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> ($stable(x_q) && $stable(y_q) && $stable(c_q))); // R3

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> (rand_o == $past(seed_x_i))); // R4

  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_bad |=> ($stable(x_q) && $stable(y_q) && seed_err_o)); // R5

  AST_NO_FIXED_POINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((x_q == '0) && (y_q == '0) && !c_q)); // R5

  AST_WRAP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && nc) |=> (x_q <= y_q)); // R2

endmodule

// File: tb/eacfib_gen_tb.sv
module eacfib_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 16-bit, carry on (scoreboard driven)
  logic        en16 = 0, ld16 = 0, sc16 = 0;
  logic [15:0] sx16 = 0, sy16 = 0;
  logic [15:0] r16;
  logic        err16, hit16;
  logic [33:0] per16;

  eacfib_gen #(.WIDTH(16), .USE_CARRY(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en16), .load_i(ld16),
    .seed_x_i(sx16), .seed_y_i(sy16), .seed_c_i(sc16),
    .rand_o(r16), .seed_err_o(err16), .period_o(per16), .period_hit_o(hit16));

  // 4-bit, carry on
  logic       en4c = 0, ld4c = 0, sc4c = 0;
  logic [3:0] sx4c = 0, sy4c = 0;
  logic [3:0] r4c;
  logic       err4c, hit4c;
  logic [9:0] per4c;

  eacfib_gen #(.WIDTH(4), .USE_CARRY(1'b1)) u_dut_w4c (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en4c), .load_i(ld4c),
    .seed_x_i(sx4c), .seed_y_i(sy4c), .seed_c_i(sc4c),
    .rand_o(r4c), .seed_err_o(err4c), .period_o(per4c), .period_hit_o(hit4c));

  // 4-bit, carry off
  logic       en4n = 0, ld4n = 0, sc4n = 0;
  logic [3:0] sx4n = 0, sy4n = 0;
  logic [3:0] r4n;
  logic       err4n, hit4n;
  logic [9:0] per4n;

  eacfib_gen #(.WIDTH(4), .USE_CARRY(1'b0)) u_dut_w4n (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en4n), .load_i(ld4n),
    .seed_x_i(sx4n), .seed_y_i(sy4n), .seed_c_i(sc4n),
    .rand_o(r4n), .seed_err_o(err4n), .period_o(per4n), .period_hit_o(hit4n));

  // scoreboard for the 16-bit instance
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m16x = 16'd1, m16y = 16'd0;
  logic        m16c = 1'b0;

  task automatic drive16(input logic e, input logic l, input logic [15:0] x,
                         input logic [15:0] y, input logic c, input string req);
    logic [16:0] t;
    @(negedge clk);
    en16 = e; ld16 = l; sx16 = x; sy16 = y; sc16 = c;
    if (l) begin
      // R5: all-zero or all-ones with carry are refused
      if (!((x == 0 && y == 0 && !c) || (x == 16'hffff && y == 16'hffff && c))) begin
        m16x = x; m16y = y; m16c = c;
      end
    end else if (e) begin
      t = {1'b0, m16x} + {1'b0, m16y} + 17'(m16c);
      m16y = m16x; m16x = t[15:0]; m16c = t[16];
    end
    exp_q.push_back(m16x);
    tag_q.push_back(req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), r16, exp_q.pop_front());
    end
  end

  task automatic seq16();
    drive16(1, 1, 16'h1234, 16'h0042, 1, "R4 load with en");
    drive16(0, 0, 0, 0, 0, "R3 hold");
    drive16(0, 0, 0, 0, 0, "R3 hold");
    drive16(0, 0, 0, 0, 0, "R3 hold");
    drive16(1, 1, 16'h0000, 16'h0000, 0, "R5 zero refused");
    drive16(1, 1, 16'hffff, 16'hffff, 1, "R5 saturated refused");
    for (int i = 0; i < 1000; i++) drive16(1, 0, 0, 0, 0, "R2 step");
    @(negedge clk);
    en16 = 0;
    wait (exp_q.size() == 0);
  endtask

  // 4-bit carry model
  logic [3:0] mcx, mcy;
  logic       mcc;
  task automatic step4c();
    logic [4:0] t;
    t = {1'b0, mcx} + {1'b0, mcy} + 5'(mcc);
    mcy = mcx; mcx = t[3:0]; mcc = t[4];
  endtask

  task automatic seq4c();
    mcx = 4'd1; mcy = 4'd0; mcc = 1'b0;
    @(negedge clk);
    en4c = 1;
    for (int i = 1; i <= 140; i++) begin
      @(negedge clk);
      step4c();
      if (i == 134) check("R8 no hit at 134", hit4c, 0);
      if (i == 135) begin
        check("R8 hit at 135", hit4c, 1);
        check("R8 period 135", per4c, 135);
        check("R8 back to seed", r4c, 1);
      end
      if (i == 140) begin
        check("R9 keeps stepping", r4c, mcx);
        check("R9 count frozen", per4c, 135);
        en4c = 0;
      end
    end
    ld4c = 1; sx4c = 0; sy4c = 0; sc4c = 0; en4c = 1;
    @(negedge clk);
    ld4c = 0; en4c = 0;
    check("R5 zero err pulse", err4c, 1);
    check("R5 zero state kept", r4c, mcx);
    ld4c = 1; sx4c = 4'hf; sy4c = 4'hf; sc4c = 1;
    @(negedge clk);
    ld4c = 0;
    check("R5 sat err pulse", err4c, 1);
    check("R5 sat state kept", r4c, mcx);
    check("R5 count untouched", per4c, 135);
    @(negedge clk);
    check("R5 err one cycle", err4c, 0);
    ld4c = 1; en4c = 1; sx4c = 4'd3; sy4c = 4'd2; sc4c = 0;
    mcx = 4'd3; mcy = 4'd2; mcc = 1'b0;
    @(negedge clk);
    ld4c = 0;
    check("R4 load value", r4c, 3);
    check("R7 restart count", per4c, 0);
    check("R7 restart hit", hit4c, 0);
    for (int i = 1; i <= 135; i++) begin
      @(negedge clk);
      step4c();
      if (i == 10) check("R7 counting", per4c, 10);
      if (i == 135) begin
        check("R8 second seed hit", hit4c, 1);
        check("R8 second seed period", per4c, 135);
        check("R8 second seed value", r4c, mcx);
        en4c = 0;
      end
    end
  endtask

  task automatic seq4n();
    @(negedge clk);
    en4n = 1;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (i == 23) check("R6 no hit at 23", hit4n, 0);
      if (i == 24) begin
        check("R6 hit at 24", hit4n, 1);
        check("R6 period 24", per4n, 24);
        check("R6 back to seed", r4n, 1);
        en4n = 0;
      end
    end
    ld4n = 1; sx4n = 0; sy4n = 0; sc4n = 1;
    @(negedge clk);
    ld4n = 0;
    check("R6 zero refused without carry", err4n, 1);
    ld4n = 1; sx4n = 4'hf; sy4n = 4'hf; sc4n = 1;
    @(negedge clk);
    ld4n = 0; en4n = 1;
    check("R6 all ones accepted", err4n, 0);
    check("R6 all ones loaded", r4n, 15);
    @(negedge clk);
    en4n = 0;
    check("R6 carry ignored", r4n, 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset rand", r16, 1);
    check("R1 reset period", per16, 0);
    check("R1 reset hit", hit16, 0);
    check("R1 reset err", err16, 0);
    check("R1 reset rand w4", r4c, 1);
    fork
      seq16();
      seq4c();
      seq4n();
    join
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule